// File: doc/BRIEF.md
# Link Bus-Request Serial Decoder

This block sits on the physical-layer side of a PHY-to-link interface. It samples a single serial request line on every rising clock edge and turns the bit stream into decoded requests. Three request kinds are handled: bus requests carrying a speed code, register reads carrying an address, and register writes carrying an address and a data byte. When a request has been fully framed, one strobe cycle presents its kind, speed, address and data.

Bus requests come in two lengths. Legacy requests are 7 bits long and carry a 2-bit speed code. Extended requests are 8 bits long and carry a 3-bit speed code. The decoder tells them apart on the fly by looking at the bits that follow the first two speed bits. This works even when a legacy request is followed directly by the start bit of the next request. A bus request whose speed is above S400 is flagged as a null-packet command, so the transmitter sends a data-prefix followed at once by a data-end, with no payload.

The block also gates two link-dependent mode enables, asynchronous arbitration acceleration and multispeed concatenation. Each enable stays off unless the attached link reports that it supports the feature.

Top module: `brq_decoder`

## Requirements
- R1: After reset, `req_valid`, `req_err`, `req_null`, `accel_en` and `mscat_en` are all 0, and no strobe fires while `lreq` stays at 0.
- R2: The line idles at 0. A frame opens with a 1 start bit, followed by a 3-bit type sent MSB first. The type codes are 001 for a bus request, 101 for a register read and 110 for a register write, and `req_kind` reports them as 0, 1 and 2 respectively.
- R3: An extended bus request sends its speed as 3 bits MSB first, followed by a 0 stop bit. When the third speed bit is 1, `req_valid` pulses in the cycle after the stop bit is captured, with the full 3-bit speed and `req_ext`=1.
- R4: A legacy bus request sends 2 speed bits and then a 0 stop bit, and is reported with speed {s1,s0,0}. The request closes on the bit after that stop bit, and `req_valid` pulses in the cycle after that bit is captured. If that bit is 1, the request is reported as legacy (`req_ext`=0). If it is 0, the request is reported as extended (`req_ext`=1) with the same speed value.
- R5: When a legacy request closes on a 1, that 1 is also the start bit of the next request, so both requests are decoded with no gap between them.
- R6: Speed 000 is S100, 010 is S200 and 100 is S400. Every other speed code, including the legacy code 11, is above S400. For such a code, `req_null` is 1 together with the bus-request strobe, and it is 0 for the three legal speeds.
- R7: A register read carries a 4-bit address, MSB first, then a stop bit. A register write carries a 4-bit address and then 8 data bits, both MSB first, then a stop bit. `req_valid` pulses in the cycle after the stop bit is captured, and the address and data are reported on `req_addr` and `req_data`.
- R8: For any other type code, `req_err` pulses for one cycle, in the cycle after the third type bit is captured. No `req_valid` pulse fires, and the decoder returns to idle, where the next 1 on the line is taken as a start bit.
- R9: `req_valid` and `req_err` each last exactly one cycle, and they are never high together.
- R10: `accel_en` equals `cfg_accel` AND `link_accel_ok`, and `mscat_en` equals `cfg_mscat` AND `link_mscat_ok`, each registered once. An enable therefore stays 0 while the link does not support its feature, whatever the configuration bit says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; `lreq` is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq | input | 1 | Serial request line from the link |
| cfg_accel | input | 1 | Configured arbitration-acceleration enable |
| cfg_mscat | input | 1 | Configured multispeed-concatenation enable |
| link_accel_ok | input | 1 | Link supports arbitration acceleration |
| link_mscat_ok | input | 1 | Link supports multispeed concatenation |
| req_valid | output | 1 | One-cycle strobe for a completed request |
| req_kind | output | 2 | 0 bus request, 1 register read, 2 register write |
| req_speed | output | 3 | Decoded 3-bit speed code (bus requests) |
| req_ext | output | 1 | 1 when the bus request was taken as 8 bits long |
| req_addr | output | 4 | Register address (reads and writes) |
| req_data | output | 8 | Register write data |
| req_null | output | 1 | Over-speed bus request: send a null packet |
| req_err | output | 1 | One-cycle strobe for an unknown request type |
| accel_en | output | 1 | Effective arbitration-acceleration enable |
| mscat_en | output | 1 | Effective multispeed-concatenation enable |

## Verification
The assertions assume that `lreq` follows the framing. Every start bit begins a complete frame, and stop bits are 0, except where a legacy request's closing bit is the next start bit. Under that assumption, strobes can never fall on adjacent cycles. The stimulus keeps to this rule by building every frame from a task that emits whole, well-formed frames. The one deliberate exception is unknown type codes, where only the start bit and type are sent before the line returns to idle. Legacy requests are sent both followed by idle and followed at once by a register read or write. Speed codes cover all three legal speeds and several over-speed values.

// File: rtl/brq_pkg.sv
package brq_pkg;

    localparam int TYPE_W = 3;

    localparam logic [TYPE_W-1:0] CODE_BUS   = 3'b001;
    localparam logic [TYPE_W-1:0] CODE_READ  = 3'b101;
    localparam logic [TYPE_W-1:0] CODE_WRITE = 3'b110;

    localparam logic [2:0] SPD_S100 = 3'b000;
    localparam logic [2:0] SPD_S200 = 3'b010;
    localparam logic [2:0] SPD_S400 = 3'b100;

    typedef enum logic [1:0] {
        RK_BUS   = 2'd0,
        RK_READ  = 2'd1,
        RK_WRITE = 2'd2
    } req_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TYPE,
        ST_SPD,
        ST_XBIT,
        ST_STOP,
        ST_TAIL,
        ST_ADDR,
        ST_DATA,
        ST_RSTOP
    } dec_state_e;

endpackage

// File: rtl/brq_frame_fsm.sv
module brq_frame_fsm
    import brq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SPD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq,
    output logic              vld,
    output logic              err,
    output req_kind_e         kind,
    output logic [SPD_W-1:0]  spd,
    output logic              ext,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int LEG_W   = SPD_W - 1;
    localparam int MAX_LEN = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        dec_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [TYPE_W-1:0] ty;
        req_kind_e         kind;
        logic [SPD_W-1:0]  spd;
        logic              ext;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              vld;
        logic              err;
    } fsm_t;

    fsm_t d, q;
    logic [TYPE_W-1:0] ty_full;

    assign ty_full = {q.ty[TYPE_W-2:0], lreq};

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (lreq) begin
                    d.st  = ST_TYPE;
                    d.cnt = '0;
                end
            end
            ST_TYPE: begin
                d.ty  = ty_full;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(TYPE_W - 1)) begin
                    d.cnt = '0;
                    case (ty_full)
                        CODE_BUS: begin
                            d.kind = RK_BUS;
                            d.st   = ST_SPD;
                        end
                        CODE_READ: begin
                            d.kind = RK_READ;
                            d.st   = ST_ADDR;
                        end
                        CODE_WRITE: begin
                            d.kind = RK_WRITE;
                            d.st   = ST_ADDR;
                        end
                        default: begin
                            d.err = 1'b1;
                            d.st  = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_SPD: begin
                d.spd = {q.spd[SPD_W-2:0], lreq};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(LEG_W - 1)) begin
                    d.cnt = '0;
                    d.st  = ST_XBIT;
                end
            end
            ST_XBIT: begin
                if (lreq) begin
                    d.spd = {q.spd[SPD_W-2:0], 1'b1};
                    d.st  = ST_STOP;
                end else begin
                    d.st  = ST_TAIL;
                end
            end
            ST_STOP: begin
                d.vld = 1'b1;
                d.ext = 1'b1;
                d.st  = ST_IDLE;
            end
            ST_TAIL: begin
                d.spd = {q.spd[SPD_W-2:0], 1'b0};
                d.vld = 1'b1;
                if (lreq) begin
                    d.ext = 1'b0;
                    d.st  = ST_TYPE;
                    d.cnt = '0;
                end else begin
                    d.ext = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_ADDR: begin
                d.addr = {q.addr[ADDR_W-2:0], lreq};
                d.cnt  = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(ADDR_W - 1)) begin
                    d.cnt = '0;
                    d.st  = (q.kind == RK_WRITE) ? ST_DATA : ST_RSTOP;
                end
            end
            ST_DATA: begin
                d.data = {q.data[DATA_W-2:0], lreq};
                d.cnt  = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(DATA_W - 1)) begin
                    d.cnt = '0;
                    d.st  = ST_RSTOP;
                end
            end
            ST_RSTOP: begin
                d.vld = 1'b1;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= RK_BUS;
        end else begin
            q <= d;
        end
    end

    assign vld  = q.vld;
    assign err  = q.err;
    assign kind = q.kind;
    assign spd  = q.spd;
    assign ext  = q.ext;
    assign addr = q.addr;
    assign data = q.data;

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld);

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> !q.err);

    // R9
    vld_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.vld && q.err));

    // R4
    legacy_low_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld && q.kind == RK_BUS && !q.ext) |-> (q.spd[0] == 1'b0));

    // R8
    err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> (q.st == ST_IDLE));

endmodule

// File: rtl/brq_speed_class.sv
module brq_speed_class
    import brq_pkg::*;
#(
    parameter int SPD_W = 3
) (
    input  logic [SPD_W-1:0] spd,
    output logic             over
);

    always_comb begin
        case (spd)
            SPD_W'(SPD_S100),
            SPD_W'(SPD_S200),
            SPD_W'(SPD_S400): over = 1'b0;
            default:          over = 1'b1;
        endcase
    end

endmodule

// File: rtl/brq_mode_gate.sv
module brq_mode_gate #(
    parameter int N_MODES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MODES-1:0] cfg_en,
    input  logic [N_MODES-1:0] link_ok,
    output logic [N_MODES-1:0] mode_en
);

    logic [N_MODES-1:0] en_d, en_q;

    for (genvar i = 0; i < N_MODES; i++) begin : g_mode
        always_comb en_d[i] = cfg_en[i] & link_ok[i];

        // R10
        unsupported_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !link_ok[i] |=> !en_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign mode_en = en_q;

endmodule

// File: rtl/brq_decoder.sv
module brq_decoder
    import brq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SPD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq,
    input  logic              cfg_accel,
    input  logic              cfg_mscat,
    input  logic              link_accel_ok,
    input  logic              link_mscat_ok,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic [SPD_W-1:0]  req_speed,
    output logic              req_ext,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              req_null,
    output logic              req_err,
    output logic              accel_en,
    output logic              mscat_en
);

    req_kind_e  kind;
    logic       over;
    logic [1:0] modes;

    brq_frame_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SPD_W  (SPD_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .lreq  (lreq),
        .vld   (req_valid),
        .err   (req_err),
        .kind  (kind),
        .spd   (req_speed),
        .ext   (req_ext),
        .addr  (req_addr),
        .data  (req_data)
    );

    brq_speed_class #(.SPD_W(SPD_W)) u_spd (
        .spd  (req_speed),
        .over (over)
    );

    brq_mode_gate #(.N_MODES(2)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  ({cfg_mscat, cfg_accel}),
        .link_ok ({link_mscat_ok, link_accel_ok}),
        .mode_en (modes)
    );

    assign req_kind = kind;
    assign req_null = req_valid && (kind == RK_BUS) && over;
    assign accel_en = modes[0];
    assign mscat_en = modes[1];

    // R6
    s400_not_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_speed == SPD_W'(SPD_S400)) |-> !req_null);

endmodule

// File: tb/brq_decoder_bench.sv
`timescale 1ns/1ps
module brq_decoder_bench;

    typedef struct packed {
        logic       err;
        logic [1:0] kind;
        logic [2:0] spd;
        logic       ext;
        logic [3:0] addr;
        logic [7:0] data;
        logic       nul;
        logic [7:0] tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lreq = 1'b0;
    logic cfg_accel = 1'b0, cfg_mscat = 1'b0, link_accel_ok = 1'b0, link_mscat_ok = 1'b0;
    logic req_valid, req_ext, req_null, req_err, accel_en, mscat_en;
    logic [1:0] req_kind;
    logic [2:0] req_speed;
    logic [3:0] req_addr;
    logic [7:0] req_data;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    brq_decoder u_brq_decoder (
        .clk(clk), .rst_n(rst_n), .lreq(lreq),
        .cfg_accel(cfg_accel), .cfg_mscat(cfg_mscat),
        .link_accel_ok(link_accel_ok), .link_mscat_ok(link_mscat_ok),
        .req_valid(req_valid), .req_kind(req_kind), .req_speed(req_speed),
        .req_ext(req_ext), .req_addr(req_addr), .req_data(req_data),
        .req_null(req_null), .req_err(req_err),
        .accel_en(accel_en), .mscat_en(mscat_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            lreq = v[i];
        end
    endtask

    task automatic idle(input int n);
        bits(32'd0, n);
    endtask

    function automatic logic is_over(input logic [2:0] s);
        return !(s == 3'b000 || s == 3'b010 || s == 3'b100);
    endfunction

    // R3 / R4: extended bus request, 8 bits
    task automatic bus_ext(input logic [2:0] s);
        sb.push_back('{1'b0, 2'd0, s, 1'b1, 4'h0, 8'h0, is_over(s), 8'd3});
        bits({24'd0, 1'b1, 3'b001, s, 1'b0}, 8);
    endtask

    // R4: legacy bus request, 7 bits; closed by next start bit when followed
    task automatic bus_leg(input logic [1:0] s, input bit followed);
        sb.push_back('{1'b0, 2'd0, {s, 1'b0}, !followed, 4'h0, 8'h0,
                       is_over({s, 1'b0}), 8'd4});
        bits({25'd0, 1'b1, 3'b001, s, 1'b0}, 7);
    endtask

    // R7
    task automatic reg_rd(input logic [3:0] a);
        sb.push_back('{1'b0, 2'd1, 3'b0, 1'b0, a, 8'h0, 1'b0, 8'd7});
        bits({23'd0, 1'b1, 3'b101, a, 1'b0}, 9);
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] dt);
        sb.push_back('{1'b0, 2'd2, 3'b0, 1'b0, a, dt, 1'b0, 8'd7});
        bits({15'd0, 1'b1, 3'b110, a, dt, 1'b0}, 17);
    endtask

    // R8
    task automatic bad_type(input logic [2:0] t);
        sb.push_back('{1'b1, 2'd0, 3'b0, 1'b0, 4'h0, 8'h0, 1'b0, 8'd8});
        bits({28'd0, 1'b1, t}, 4);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && (req_valid || req_err)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected strobe", {req_valid, req_err}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.err) begin
                    check(req_err && !req_valid, "R8", "error strobe",
                          {req_err, req_valid}, 2'b10);
                end else begin
                    check(req_valid && !req_err, "R9", "valid strobe",
                          {req_valid, req_err}, 2'b10);
                    check(req_kind == e.kind, "R2", "kind", req_kind, e.kind);
                    if (e.kind == 2'd0) begin
                        check(req_speed == e.spd,
                              (e.tag == 8'd3) ? "R3" : "R4", "speed",
                              req_speed, e.spd);
                        check(req_ext == e.ext, (e.tag == 8'd3) ? "R3" : "R5",
                              "ext", req_ext, e.ext);
                        check(req_null == e.nul, "R6", "null", req_null, e.nul);
                    end else begin
                        check(req_addr == e.addr, "R7", "addr", req_addr, e.addr);
                        if (e.kind == 2'd2)
                            check(req_data == e.data, "R7", "data", req_data, e.data);
                    end
                end
            end
        end
    end

    // R9: no two strobes on adjacent cycles
    logic prev_strobe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_strobe && (req_valid || req_err))
                check(1'b0, "R9", "strobe longer than one cycle", 1, 0);
            prev_strobe <= req_valid || req_err;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            check(1'b0, "R1", "watchdog expired", cycles, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!req_valid && !req_err && !req_null, "R1", "reset strobes",
              {req_valid, req_err, req_null}, 0);
        check(!accel_en && !mscat_en, "R1", "reset enables", {accel_en, mscat_en}, 0);
        idle(5);

        bus_ext(3'b000); idle(2);
        bus_ext(3'b010); idle(1);
        bus_ext(3'b100); idle(3);
        bus_ext(3'b011); idle(2);
        bus_ext(3'b111); idle(2);
        bus_ext(3'b101); bus_ext(3'b001); idle(2);

        bus_leg(2'b00, 1'b0); idle(3);
        bus_leg(2'b01, 1'b0); idle(3);
        bus_leg(2'b10, 1'b0); idle(3);
        bus_leg(2'b11, 1'b0); idle(3);

        // R5: legacy directly followed by another request
        bus_leg(2'b10, 1'b1); reg_rd(4'hA); idle(2);
        bus_leg(2'b01, 1'b1); reg_wr(4'h5, 8'hC3); idle(2);
        bus_leg(2'b11, 1'b1); bus_ext(3'b100); idle(2);
        bus_leg(2'b00, 1'b1); bus_leg(2'b10, 1'b0); idle(3);

        reg_rd(4'h0); reg_rd(4'hF); idle(1);
        reg_wr(4'h9, 8'h00); reg_wr(4'h3, 8'hFF); idle(2);

        bad_type(3'b111); idle(2);
        bad_type(3'b000); bus_ext(3'b010); idle(2);
        bad_type(3'b011); reg_rd(4'h6); idle(4);

        // R10
        cfg_accel = 1'b1; cfg_mscat = 1'b1;
        @(negedge clk); @(negedge clk);
        check(!accel_en && !mscat_en, "R10", "gated off unsupported",
              {accel_en, mscat_en}, 0);
        link_accel_ok = 1'b1;
        @(negedge clk);
        check(accel_en && !mscat_en, "R10", "accel only",
              {accel_en, mscat_en}, 2'b10);
        link_mscat_ok = 1'b1;
        @(negedge clk);
        check(accel_en && mscat_en, "R10", "both", {accel_en, mscat_en}, 2'b11);
        cfg_accel = 1'b0;
        @(negedge clk);
        check(!accel_en && mscat_en, "R10", "cfg off", {accel_en, mscat_en}, 2'b01);
        link_mscat_ok = 1'b0;
        @(negedge clk);
        check(!mscat_en, "R10", "link drop", mscat_en, 0);

        idle(4);
        check(sb.size() == 0, "R2", "pending expected items", sb.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule